// File: doc/BRIEF.md
# Cascadable Serial Display-RAM Loader

This block takes a serial word on a single data pin, one bit per falling edge of the serial clock, and writes it into a small register file that holds one 40-bit column pattern per display row. A mode input picks the word length. In the short form, the word is 40 bits: column bits, then one address bit per row. In the long form, the word is 48 bits: 40 column bits, then 8 address bits. The address field is a set of write enables, not a binary number. A strobe can therefore write the same pattern to several rows, or to no row at all.

The shift chain also drives a serial output. That output repeats the input exactly one word length later, so several loaders can share the clock and the strobe, with each output feeding the next input. A row scanner reads the register file through an asynchronous read port. While the strobe is high, the shift chain holds its contents. The write happens on the first falling clock edge that samples the strobe low again.

Top module: `dispram_loader`

## Requirements
- R1: When the synchronous active-high reset is applied, `sdo` goes to 0 and every row of the register file reads 0.
- R2: With `col_mode` = 0 and `strobe` low, `sdo` repeats `sdi` delayed by exactly 40 clock periods. Input is sampled on the falling edge and `sdo` changes on the rising edge.
- R3: With `col_mode` = 1 and `strobe` low, `sdo` repeats `sdi` delayed by exactly 48 clock periods.
- R4: Short word (`col_mode` = 0, n = MUX_RATE). Number the bits 1 to 40, with bit 40 shifted in first and bit 1 last. Bits 1..n are the address, and bit k enables row k-1. Bits n+1..40 go to row bits 0..39-n in ascending order. Row bits 40-n..39 are written as 0.
- R5: Long word (`col_mode` = 1). Number the bits 1 to 48, with bit 48 first. Bits 1..8 are the address, and bit k enables row k-1. Bits 9..48 go to row bits 0..39.
- R6: One strobe falling edge (high, then sampled low) writes the same column pattern to every row whose address bit is 1, exactly once.
- R7: A strobe whose address bits are all 0 leaves every row unchanged.
- R8: In the long word, address bits that select a row number at or above MUX_RATE are ignored.
- R9: While `strobe` is sampled high, the shift chain does not shift. Bits clocked in during that time are lost, and `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; shifting on falling edge, `sdo` on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in |
| col_mode | input | 1 | 0: 40-bit word, 1: 48-bit word |
| strobe | input | 1 | Write strobe; holds the chain while high, writes on its falling edge |
| sdo | output | 1 | Serial data out to the next chained loader |
| rd_row | input | $clog2(MUX_RATE) | Row read by the scanner |
| rd_data | output | 40 | Column pattern of the row `rd_row` |

## Verification
The bench builds the loader with MUX_RATE = 4. With that value the short word has a 4-bit address and 36 column bits, so the zero-filled upper row bits can be observed. In the long word, address bits 5 to 8 point beyond the four rows, which makes the ignored-address case reachable. A pseudo-random stream is run through the chain in both modes to measure the 40- and 48-cycle delays.

// File: rtl/dispram_pkg.sv
package dispram_pkg;

    localparam int unsigned COL_W     = 40;
    localparam int unsigned SHORT_LEN = 40;
    localparam int unsigned LONG_ADDR = 8;
    localparam int unsigned LONG_LEN  = COL_W + LONG_ADDR;

    typedef logic [COL_W-1:0] col_word_t;

    // View of the shift chain once a long word is complete.
    typedef struct packed {
        col_word_t              cols;
        logic [LONG_ADDR-1:0]   addr;
    } long_word_t;

    // Column pattern carried by the chain, for either word length.
    function automatic col_word_t column_bits(input logic [LONG_LEN-1:0] chain,
                                              input logic long_mode,
                                              input int unsigned mux);
        long_word_t lw;
        col_word_t  c;
        lw = long_word_t'(chain);
        c  = '0;
        if (long_mode) begin
            c = lw.cols;
        end else begin
            for (int i = 0; i < int'(COL_W); i++) begin
                if (i < int'(SHORT_LEN - mux)) c[i] = chain[i + int'(mux)];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/ldr_shift.sv
module ldr_shift
    import dispram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sdi,
    input  logic                long_mode,
    input  logic                hold,
    output logic [LONG_LEN-1:0] chain_q,
    output logic                sdo
);

    logic tap;

    always_ff @(negedge clk) begin
        if (rst)        chain_q <= '0;
        else if (!hold) chain_q <= {chain_q[LONG_LEN-2:0], sdi};
    end

    assign tap = long_mode ? chain_q[LONG_LEN-1] : chain_q[SHORT_LEN-1];

    always_ff @(posedge clk) begin
        if (rst) sdo <= 1'b0;
        else     sdo <= tap;
    end

    // Count of uninterrupted shifting edges, used by the delay checks.
    logic [5:0] run_cnt;
    always_ff @(negedge clk) begin
        if (rst || hold)          run_cnt <= '0;
        else if (run_cnt != 6'h3f) run_cnt <= run_cnt + 6'd1;
    end

    // R2
    delay_short_chk: assert property (@(negedge clk) disable iff (rst)
        (run_cnt >= 6'd40) |-> (chain_q[SHORT_LEN-1] == $past(sdi, 40)));

    // R3
    delay_long_chk: assert property (@(negedge clk) disable iff (rst)
        (run_cnt >= 6'd48) |-> (chain_q[LONG_LEN-1] == $past(sdi, 48)));

    // R9
    hold_chain_chk: assert property (@(negedge clk) disable iff (rst)
        hold |=> $stable(chain_q));

endmodule

// File: rtl/ldr_strobe.sv
module ldr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic hold,
    output logic fire
);

    logic stb_q;

    always_ff @(negedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= strobe;
    end

    assign hold = strobe;
    assign fire = stb_q & ~strobe;

    // R6
    single_write_chk: assert property (@(negedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/ldr_rowfile.sv
module ldr_rowfile
    import dispram_pkg::*;
#(
    parameter int unsigned ROWS  = 8,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ROWS-1:0]  wen,
    input  col_word_t        wdata,
    input  logic [ROW_W-1:0] rd_row,
    output col_word_t        rd_data
);

    col_word_t rows_q [ROWS];

    for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
        always_ff @(negedge clk) begin
            if (rst)                rows_q[r] <= '0;
            else if (we && wen[r])  rows_q[r] <= wdata;
        end

        // R7 R8
        row_keep_chk: assert property (@(negedge clk) disable iff (rst)
            !(we && wen[r]) |=> $stable(rows_q[r]));

        // R6
        row_write_chk: assert property (@(negedge clk) disable iff (rst)
            (we && wen[r]) |=> (rows_q[r] == $past(wdata)));
    end

    assign rd_data = rows_q[rd_row];

endmodule

// File: rtl/dispram_loader.sv
module dispram_loader
    import dispram_pkg::*;
#(
    parameter int unsigned MUX_RATE = 8,
    localparam int unsigned ROWS  = MUX_RATE,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdi,
    input  logic             col_mode,
    input  logic             strobe,
    output logic             sdo,
    input  logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_data
);

    logic [LONG_LEN-1:0] chain;
    logic                hold;
    logic                fire;
    logic [ROWS-1:0]     wen;
    col_word_t           wdata;

    ldr_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .hold   (hold),
        .fire   (fire)
    );

    ldr_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sdi       (sdi),
        .long_mode (col_mode),
        .hold      (hold),
        .chain_q   (chain),
        .sdo       (sdo)
    );

    // Address bit k (last bits shifted) enables row k-1 in both word forms;
    // long-form bits beyond the row count fall outside this slice.
    assign wen   = chain[ROWS-1:0];
    assign wdata = column_bits(chain, col_mode, MUX_RATE);

    ldr_rowfile #(.ROWS(ROWS)) u_rows (
        .clk     (clk),
        .rst     (rst),
        .we      (fire),
        .wen     (wen),
        .wdata   (wdata),
        .rd_row  (rd_row),
        .rd_data (rd_data)
    );

    // R1
    sdo_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (sdo == 1'b0));

endmodule

// File: tb/dispram_loader_test.sv
module dispram_loader_test;

    localparam int CLK_PERIOD = 20;
    localparam int MR = 4;
    localparam int RW = $clog2(MR);

    typedef struct packed {
        logic        col;
        logic [7:0]  addr;
        logic [39:0] cols;
    } vec_t;

    // R4 R5 R6 R7 R8 vectors
    localparam vec_t VECS [7] = '{
        '{col: 1'b0, addr: 8'h01, cols: 40'h00_9A_5C_3E_71},
        '{col: 1'b1, addr: 8'h06, cols: 40'hA5_C3_0F_F0_99},
        '{col: 1'b0, addr: 8'h0F, cols: 40'hFF_FF_FF_FF_FF},
        '{col: 1'b1, addr: 8'h00, cols: 40'h12_34_56_78_9A},
        '{col: 1'b1, addr: 8'hF0, cols: 40'h0F_0F_0F_0F_0F},
        '{col: 1'b1, addr: 8'h98, cols: 40'hDE_AD_BE_EF_01},
        '{col: 1'b0, addr: 8'h00, cols: 40'h11_22_33_44_55}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sdi = 1'b0;
    logic          col_mode = 1'b0;
    logic          strobe = 1'b0;
    logic          sdo;
    logic [RW-1:0] rd_row = '0;
    logic [39:0]   rd_data;

    int checks = 0;
    int fails  = 0;
    logic [39:0] exp_rows [MR];
    logic hist [160];

    always #(CLK_PERIOD/2) clk = ~clk;

    dispram_loader #(.MUX_RATE(MR)) uut (
        .clk(clk), .rst(rst), .sdi(sdi), .col_mode(col_mode),
        .strobe(strobe), .sdo(sdo), .rd_row(rd_row), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive just after the rising edge, leave 1 ns before sampling.
    task automatic tick(input logic d, input logic s);
        @(posedge clk);
        #1;
        sdi = d;
        strobe = s;
        #1;
    endtask

    task automatic check_rows(input string req);
        for (int r = 0; r < MR; r++) begin
            rd_row = RW'(r);
            #1;
            check(req, rd_data, exp_rows[r]);
        end
    endtask

    task automatic send_word(input vec_t v);
        logic [47:0] w;
        int len;
        w = '0;
        col_mode = v.col;
        if (v.col) begin
            w = {v.cols, v.addr};
            len = 48;
        end else begin
            for (int i = 0; i < 40; i++) w[i] = (i < MR) ? v.addr[i] : v.cols[i-MR];
            len = 40;
        end
        for (int k = len - 1; k >= 0; k--) tick(w[k], 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int r = 0; r < MR; r++) begin
            if (v.addr[r]) begin
                if (v.col) exp_rows[r] = v.cols;
                else begin
                    exp_rows[r] = '0;
                    for (int i = 0; i < 40 - MR; i++) exp_rows[r][i] = v.cols[i];
                end
            end
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        strobe = 1'b0;
        repeat (3) tick(1'b0, 1'b0);
        for (int r = 0; r < MR; r++) exp_rows[r] = '0;
    endtask

    task automatic delay_test(input logic mode, input int len, input string req);
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int k = 0; k < 160; k++) begin
            hist[k] = lf[0];
            lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
        col_mode = mode;
        do_reset();
        @(posedge clk);
        #1;
        rst = 1'b0;
        sdi = hist[0];
        strobe = 1'b0;
        #1;
        for (int k = 1; k < 160; k++) begin
            tick(hist[k], 1'b0);
            check(req, 40'(sdo), (k >= len) ? 40'(hist[k-len]) : 40'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [39:0] held;
        logic        sdo_held;

        // R1 reset state
        do_reset();
        @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        check("R1 sdo", 40'(sdo), 40'h0);
        check_rows("R1 rows");

        // Table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < 7; i++) begin
            send_word(VECS[i]);
            check_rows($sformatf("R4 R5 R6 R7 R8 vector %0d", i));
        end

        // R7 sync-only strobe in short mode leaves all rows
        send_word('{col: 1'b0, addr: 8'h00, cols: 40'hFF_FF_FF_FF_FF});
        check_rows("R7 zero address");

        // R8 only out-of-range bits set in long mode
        send_word('{col: 1'b1, addr: 8'hE0, cols: 40'h55_55_55_55_55});
        check_rows("R8 ignored address");

        // R9 chain holds while strobe high; bits clocked then are lost
        held = 40'h3C_5A_A5_C3_81;
        col_mode = 1'b1;
        for (int k = 47; k >= 0; k--) tick((k >= 8) ? held[k-8] : (k == 1), 1'b0);
        tick(1'b1, 1'b1);
        sdo_held = sdo;
        for (int j = 0; j < 5; j++) begin
            tick(1'b1, 1'b1);
            check("R9 sdo frozen", 40'(sdo), 40'(sdo_held));
        end
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        exp_rows[1] = held;
        check_rows("R9 held word");

        // R1 mid-run reset clears written rows
        do_reset();
        check_rows("R1 reset clears rows");
        check("R1 sdo cleared", 40'(sdo), 40'h0);

        // R2 and R3 delay lines
        delay_test(1'b0, 40, "R2 delay 40");
        delay_test(1'b1, 48, "R3 delay 48");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule